// File: doc/BRIEF.md
# Handshaked Byte-Serial Packet Transceiver

This block is the host end of a half-duplex byte link to a small management controller. Three wires carry the handshake. The host drives a frame-active line (`frame_n`, low while a frame runs) and an acknowledge line (`ack`). The controller drives an active-low request line (`req_n`). Each byte moves through a separate shift unit. The block gives that unit a direction select, the byte to shift out, and the byte shifted in, and it gets back one strobe per finished byte.

One outbound packet of up to `TX_MAX` bytes is loaded through a valid/ready handshake. It is held until every byte has gone out, however many collisions occur. Inbound frames are reported byte by byte and then summarised as a type byte, a payload length and an overflow flag.

Both ends may start a frame in the same cycle. When that happens, reception wins: the send is dropped, the incoming frame is read, and the whole packet is then sent again from its first byte. Every wait (the power-up sequence, the collision guard and the settle time after a receive) counts clock cycles derived from `CLK_KHZ`. While a wait runs, `busy` is high and new packets are refused.

Top module: `hs_xcvr`

## Requirements
- R1: After reset, the block holds both host lines high for one guard time. It then steps `{frame_n,ack}` through 01, 00, 10, 11, with at least one guard time (`GUARD_US` microseconds) between steps. `busy` is high for the whole sequence.
- R2: In the idle state, `frame_n` and `ack` are both high and `sh_dir_out` is 0 (input).
- R3: A packet is taken on a cycle where `tx_valid` and `tx_ready` are both high. Byte i of the packet sits in `tx_data[8i+7:8i]`, and `tx_len` is its length (1 to `TX_MAX`). `tx_ready` stays low from that cycle until the last byte of that packet has been sent.
- R4: A send starts only from idle, and only while `req_n` is high. In the cycle it starts, `sh_dir_out` goes to 1, `sh_wr_byte` holds byte 0, `ack` is high and `frame_n` goes low.
- R5: Each strobe during a send, with `req_n` high and bytes still to go, loads the next byte and inverts `ack`.
- R6: The strobe for the last byte ends the send. `sh_dir_out` returns to 0, both lines return high and `tx_ready` rises again.
- R7: A strobe during a send while `req_n` is low is a collision. It returns the lines to idle, sets the direction to input and starts a guard wait. If `req_n` is still low after the wait, a receive starts. The packet is later resent from byte 0.
- R8: A strobe while idle carries a discarded dummy byte. If `req_n` is low, `frame_n` goes low and a receive starts. If `req_n` is high, no receive starts, and any pending send restarts from byte 0 after a guard wait.
- R9: In receive, each strobe stores one byte, reported on `rx_byte` with its index (index 0 is the first byte). While `req_n` stays low, each strobe inverts `ack`. A strobe with `req_n` high is the last byte.
- R10: At the end of a frame, both lines return high and `rx_done` pulses. `rx_type` is the first stored byte and `rx_len` is the number of bytes stored minus one.
- R11: The 256th stored byte (`RX_MAX`) ends the frame even if `req_n` is still low. `rx_overflow` is then set and `rx_len` is 255.
- R12: If a send is pending when a receive ends, the block waits the settle time (`SETTLE_US` microseconds) with the lines idle. It then receives again if `req_n` is low, or restarts the send from byte 0 if not.
- R13: While any wait runs, `busy` is high and a packet offered on `tx_valid` is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Outbound packet offered |
| tx_ready | output | 1 | Packet can be accepted |
| tx_len | input | LW | Packet length in bytes |
| tx_data | input | 8*TX_MAX | Packet bytes, byte 0 in the low bits |
| sh_dir_out | output | 1 | Shift direction, 1 = output |
| sh_wr_byte | output | 8 | Byte to shift out |
| sh_rd_byte | input | 8 | Byte shifted in |
| sh_done | input | 1 | Byte-complete strobe |
| frame_n | output | 1 | Frame-active line, active low |
| ack | output | 1 | Acknowledge line |
| req_n | input | 1 | Peripheral request, active low |
| rx_byte_valid | output | 1 | A received byte is presented |
| rx_byte_idx | output | XW | Position of that byte in the frame |
| rx_byte | output | 8 | Received byte |
| rx_done | output | 1 | Frame-end pulse |
| rx_type | output | 8 | First byte of the finished frame |
| rx_len | output | CW | Payload length of the finished frame |
| rx_overflow | output | 1 | Frame ended at the buffer limit |
| busy | output | 1 | A wait is running |

## Verification
The assertions check on every cycle that:
- the lines are idle with input direction whenever the state is idle;
- a send starts only with `frame_n` low and `ack` high, after `req_n` was seen high;
- every mid-packet strobe inverts `ack`;
- a collision strobe returns the lines to idle on the next cycle;
- an accepted packet drops `tx_ready`;
- an overflow report carries the maximum length.

Some behaviours show only over whole scenarios, and the bench covers these. They are the order and spacing of the power-up sequence, the replay of the whole packet from byte 0 after one or two collisions, the choice made at the end of the settle wait, and the exact bytes, indices, types and lengths of received frames.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_OUT, ST_IN, ST_GUARD, ST_SETTLE
  } hs_state_t;

  // microseconds to clock cycles, never below two
  function automatic int us_cycles(input int khz, input int us);
    int c;
    c = (khz / 10) * us / 100;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hs_delay.sv
module hs_delay #(
  parameter int W    = 8,
  parameter int INIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] len,
  output logic         done,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= W'(INIT);
    else if (go)          cnt <= len;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign done = (cnt == W'(1));
  assign busy = (cnt != '0);
endmodule

// File: rtl/hs_txhold.sv
module hs_txhold #(
  parameter int TX_MAX = 16,
  localparam int LW = $clog2(TX_MAX + 1),
  localparam int IW = $clog2(TX_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [LW-1:0]       len_in,
  input  logic [8*TX_MAX-1:0] data_in,
  input  logic                clr,
  input  logic [IW-1:0]       sel,
  output logic                pend,
  output logic [LW-1:0]       len,
  output logic [7:0]          byte_out
);
  logic [7:0] mem [TX_MAX];

  for (genvar g = 0; g < TX_MAX; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[g] <= '0;
      else if (accept) mem[g] <= data_in[8*g +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      len  <= '0;
    end else if (accept) begin
      pend <= 1'b1;
      len  <= len_in;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end

  assign byte_out = mem[sel];
endmodule

// File: rtl/hs_rxtrack.sv
module hs_rxtrack #(
  parameter int RX_MAX = 256,
  localparam int CW = $clog2(RX_MAX + 1),
  localparam int XW = $clog2(RX_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  logic          fin,
  input  logic          ovf,
  input  logic [7:0]    din,
  output logic [CW-1:0] cnt,
  output logic          rx_byte_valid,
  output logic [XW-1:0] rx_byte_idx,
  output logic [7:0]    rx_byte,
  output logic          rx_done,
  output logic [7:0]    rx_type,
  output logic [CW-1:0] rx_len,
  output logic          rx_overflow
);
  logic [7:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; first_q <= '0;
      rx_byte_valid <= 1'b0; rx_byte_idx <= '0; rx_byte <= '0;
      rx_done <= 1'b0; rx_type <= '0; rx_len <= '0; rx_overflow <= 1'b0;
    end else begin
      rx_byte_valid <= store;
      rx_done       <= fin;
      if (store) begin
        rx_byte     <= din;
        rx_byte_idx <= cnt[XW-1:0];
        cnt         <= cnt + CW'(1);
        if (cnt == '0) first_q <= din;
      end
      if (fin) begin
        rx_len      <= cnt;
        rx_type     <= (cnt == '0) ? din : first_q;
        rx_overflow <= ovf;
        cnt         <= '0;
      end
    end
  end
endmodule

// File: rtl/hs_xcvr.sv
module hs_xcvr
  import hs_pkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int GUARD_US  = 150,
  parameter int SETTLE_US = 1500,
  parameter int TX_MAX    = 16,
  parameter int RX_MAX    = 256,
  localparam int LW = $clog2(TX_MAX + 1),
  localparam int IW = $clog2(TX_MAX),
  localparam int CW = $clog2(RX_MAX + 1),
  localparam int XW = $clog2(RX_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [LW-1:0]       tx_len,
  input  logic [8*TX_MAX-1:0] tx_data,
  output logic                sh_dir_out,
  output logic [7:0]          sh_wr_byte,
  input  logic [7:0]          sh_rd_byte,
  input  logic                sh_done,
  output logic                frame_n,
  output logic                ack,
  input  logic                req_n,
  output logic                rx_byte_valid,
  output logic [XW-1:0]       rx_byte_idx,
  output logic [7:0]          rx_byte,
  output logic                rx_done,
  output logic [7:0]          rx_type,
  output logic [CW-1:0]       rx_len,
  output logic                rx_overflow,
  output logic                busy
);
  localparam int GUARD_CYC  = us_cycles(CLK_KHZ, GUARD_US);
  localparam int SETTLE_CYC = us_cycles(CLK_KHZ, SETTLE_US);
  localparam int TW = $clog2(max2(GUARD_CYC, SETTLE_CYC) + 1);

  hs_state_t st;
  logic [1:0]    phase;
  logic [IW-1:0] sent;
  logic [LW-1:0] sent_nx, hold_len;
  logic [IW-1:0] sel;
  logic [7:0]    hold_byte;
  logic [CW-1:0] rcnt;
  logic          pend, accept, t_go, t_done, t_busy;
  logic [TW-1:0] t_len;

  // named events shared by the FSM and the checker
  logic st_idle, wait_end;
  logic ev_rx_go, ev_send_go, ev_spur, ev_coll, ev_tx_last, ev_tx_next;
  logic ev_rx_byte, ev_rx_end, ev_rx_ovf;

  assign sent_nx  = LW'(sent) + LW'(1);
  assign sel      = (st == ST_OUT) ? sent_nx[IW-1:0] : '0;
  assign st_idle  = (st == ST_IDLE);
  assign wait_end = (st == ST_GUARD || st == ST_SETTLE) && t_done;

  assign ev_rx_go   = (st_idle && sh_done && !req_n) || (wait_end && !req_n);
  assign ev_spur    = st_idle && sh_done && req_n;
  assign ev_send_go = (st_idle && !sh_done && pend && req_n) ||
                      (wait_end && req_n && pend);
  assign ev_coll    = (st == ST_OUT) && sh_done && !req_n;
  assign ev_tx_last = (st == ST_OUT) && sh_done && req_n && (sent_nx == hold_len);
  assign ev_tx_next = (st == ST_OUT) && sh_done && req_n && (sent_nx != hold_len);
  assign ev_rx_byte = (st == ST_IN) && sh_done;
  assign ev_rx_ovf  = ev_rx_byte && !req_n && (rcnt == CW'(RX_MAX - 1));
  assign ev_rx_end  = ev_rx_byte && (req_n || ev_rx_ovf);

  assign t_go  = (st == ST_BOOT && t_done && phase != 2'd3) || ev_coll ||
                 (ev_spur && pend) || (ev_rx_end && pend);
  assign t_len = ev_rx_end ? TW'(SETTLE_CYC) : TW'(GUARD_CYC);

  assign accept   = tx_valid && tx_ready;
  assign tx_ready = !pend && !t_busy;
  assign busy     = t_busy;

  hs_delay #(.W(TW), .INIT(GUARD_CYC)) u_delay (
    .clk(clk), .rst_n(rst_n), .go(t_go), .len(t_len),
    .done(t_done), .busy(t_busy));

  hs_txhold #(.TX_MAX(TX_MAX)) u_tx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .len_in(tx_len),
    .data_in(tx_data), .clr(ev_tx_last), .sel(sel),
    .pend(pend), .len(hold_len), .byte_out(hold_byte));

  hs_rxtrack #(.RX_MAX(RX_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .store(ev_rx_byte), .fin(ev_rx_end),
    .ovf(ev_rx_ovf), .din(sh_rd_byte), .cnt(rcnt),
    .rx_byte_valid(rx_byte_valid), .rx_byte_idx(rx_byte_idx),
    .rx_byte(rx_byte), .rx_done(rx_done), .rx_type(rx_type),
    .rx_len(rx_len), .rx_overflow(rx_overflow));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_BOOT; phase <= '0; sent <= '0;
      frame_n <= 1'b1; ack <= 1'b1; sh_dir_out <= 1'b0; sh_wr_byte <= '0;
    end else if (ev_rx_go) begin
      sh_dir_out <= 1'b0; frame_n <= 1'b0; ack <= 1'b1; st <= ST_IN;
    end else if (ev_send_go) begin
      sh_dir_out <= 1'b1; sh_wr_byte <= hold_byte; ack <= 1'b1;
      frame_n <= 1'b0; sent <= '0; st <= ST_OUT;
    end else begin
      case (st)
        ST_BOOT: if (t_done) begin
          phase <= phase + 2'd1;
          case (phase)
            2'd0:    frame_n <= 1'b0;
            2'd1:    ack <= ~ack;
            2'd2:    frame_n <= 1'b1;
            default: begin ack <= 1'b1; st <= ST_IDLE; end
          endcase
        end
        ST_IDLE: if (ev_spur && pend) st <= ST_GUARD;
        ST_OUT: begin
          if (ev_coll || ev_tx_last) begin
            sh_dir_out <= 1'b0; frame_n <= 1'b1; ack <= 1'b1; sent <= '0;
            st <= ev_coll ? ST_GUARD : ST_IDLE;
          end else if (ev_tx_next) begin
            sh_wr_byte <= hold_byte; ack <= ~ack; sent <= sent_nx[IW-1:0];
          end
        end
        ST_IN: if (ev_rx_end) begin
          frame_n <= 1'b1; ack <= 1'b1; st <= pend ? ST_SETTLE : ST_IDLE;
        end else if (ev_rx_byte) begin
          ack <= ~ack;
        end
        ST_GUARD, ST_SETTLE: if (t_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_xcvr_chk.sv
module hs_xcvr_chk #(
  parameter int CW     = 9,
  parameter int RX_MAX = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_n,
  input logic          ack,
  input logic          sh_dir_out,
  input logic          sh_done,
  input logic          req_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_done,
  input logic [CW-1:0] rx_len,
  input logic          rx_overflow,
  input logic          st_idle,
  input logic          ev_tx_next
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> frame_n && ack && !sh_dir_out); // R2
  AST_SEND_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_dir_out) |-> !frame_n && ack && $past(req_n)); // R4
  AST_OUT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sh_dir_out |-> !frame_n); // R4
  AST_ACK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_next |=> (ack != $past(ack)) && !frame_n && sh_dir_out); // R5
  AST_COLLIDE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_dir_out && sh_done && !req_n) |=> !sh_dir_out && frame_n && ack); // R7
  AST_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R3
  AST_OVF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_overflow) |-> rx_len == CW'(RX_MAX - 1)); // R11
endmodule

bind hs_xcvr hs_xcvr_chk #(.CW(CW), .RX_MAX(RX_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ack(ack),
  .sh_dir_out(sh_dir_out), .sh_done(sh_done), .req_n(req_n),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_done(rx_done),
  .rx_len(rx_len), .rx_overflow(rx_overflow), .st_idle(st_idle),
  .ev_tx_next(ev_tx_next));

// File: tb/sim_hs_xcvr.sv
`timescale 1ns/1ps
module sim_hs_xcvr;
  localparam int KHZ = 100;            // scaled clock so waits stay short
  localparam int GUARD = 15;           // 150 us at KHZ
  localparam int TXM = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_ready;
  logic [4:0] tx_len = '0;
  logic [8*TXM-1:0] tx_data = '0;
  logic sh_dir_out, sh_done = 1'b0, frame_n, ack, req_n = 1'b1;
  logic [7:0] sh_wr_byte, sh_rd_byte = '0;
  logic rx_byte_valid, rx_done, rx_overflow, busy;
  logic [7:0] rx_byte_idx, rx_byte, rx_type;
  logic [8:0] rx_len;

  always #2 clk = ~clk;

  hs_xcvr #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_len(tx_len), .tx_data(tx_data), .sh_dir_out(sh_dir_out),
    .sh_wr_byte(sh_wr_byte), .sh_rd_byte(sh_rd_byte), .sh_done(sh_done),
    .frame_n(frame_n), .ack(ack), .req_n(req_n),
    .rx_byte_valid(rx_byte_valid), .rx_byte_idx(rx_byte_idx),
    .rx_byte(rx_byte), .rx_done(rx_done), .rx_type(rx_type),
    .rx_len(rx_len), .rx_overflow(rx_overflow), .busy(busy));

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  logic [7:0]  txq[$];                 // bytes the peripheral must see
  logic [15:0] rbq[$];                 // {idx, data} expected per stored byte
  logic [17:0] frq[$];                 // {ovf, len, type} expected per frame

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] d, input logic rq);
    sh_rd_byte = d; req_n = rq; sh_done = 1'b1;
    @(negedge clk);
    sh_done = 1'b0;
  endtask

  task automatic wait_frame(input logic v, input string rq);
    int k = 0;
    while (frame_n !== v && k < 2000) begin @(negedge clk); k++; end
    chk(rq, {31'd0, frame_n}, {31'd0, v});
  endtask

  task automatic offer(input int n, input logic [8*TXM-1:0] d);
    int k = 0;
    while (!tx_ready && k < 2000) begin @(negedge clk); k++; end
    tx_valid = 1'b1; tx_len = 5'(n); tx_data = d;
    for (int i = 0; i < n; i++) txq.push_back(d[8*i +: 8]);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // peripheral takes one outbound byte; scoreboard compares it
  task automatic take(input string rq);
    logic [7:0] e;
    e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
    chk(rq, {24'd0, sh_wr_byte}, {24'd0, e});
    chk(rq, {31'd0, sh_dir_out}, 32'd1);
    strobe(8'h00, 1'b1);
  endtask

  task automatic rx_frame(input logic [7:0] typ, input int npay,
                          input logic [7:0] base, input logic end_high);
    logic prev;
    frq.push_back({(npay == 255 && !end_high), 9'(npay), typ});
    for (int i = 0; i <= npay; i++) begin
      logic [7:0] d;
      logic last;
      d = (i == 0) ? typ : 8'(base + i);
      last = (i == npay);
      rbq.push_back({8'(i), d});
      prev = ack;
      strobe(d, last ? end_high : 1'b0);
      if (!last) chk("R9 ack inverts per received byte", {31'd0, ack}, {31'd0, ~prev});
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rx_byte_valid) begin
      logic [15:0] e;
      e = (rbq.size() > 0) ? rbq.pop_front() : 16'hxxxx;
      chk("R9 stored byte idx/data", {16'd0, rx_byte_idx, rx_byte}, {16'd0, e});
    end
    if (rx_done) begin
      logic [17:0] f;
      f = (frq.size() > 0) ? frq.pop_front() : 18'hxxxxx;
      chk("R10 R11 frame ovf/len/type", {14'd0, rx_overflow, rx_len, rx_type}, {14'd0, f});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [1:0] seq [4];
    int gap [4];
    int nseq, last_t;
    logic [1:0] cur;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lines high after reset", {30'd0, frame_n, ack}, 32'd3);
    chk("R13 busy during power-up", {31'd0, busy}, 32'd1);
    chk("R13 not ready during power-up", {31'd0, tx_ready}, 32'd0);
    // power-up sequence, with a packet offered while busy
    nseq = 0; last_t = 0; cur = 2'b11;
    for (int k = 1; k < 500 && busy; k++) begin
      if (k == 5) begin tx_valid = 1'b1; tx_len = 5'd1; tx_data = 8'hEE; end
      if (k == 6) tx_valid = 1'b0;
      @(negedge clk);
      if ({frame_n, ack} != cur && nseq < 4) begin
        cur = {frame_n, ack}; seq[nseq] = cur; gap[nseq] = k - last_t;
        last_t = k; nseq++;
      end
    end
    chk("R1 step count", nseq, 4);
    chk("R1 step order", {24'd0, seq[0], seq[1], seq[2], seq[3]}, {24'd0, 8'b01_00_10_11});
    for (int i = 1; i < 4; i++) chk("R1 guard between steps", gap[i] >= GUARD, 1);
    cyc(3);
    chk("R13 packet offered while busy was dropped", {31'd0, frame_n}, 32'd1);
    chk("R2 idle lines and input direction", {29'd0, frame_n, ack, sh_dir_out}, 32'd6);
    chk("R2 ready when idle", {31'd0, tx_ready}, 32'd1);

    // plain three-byte send
    offer(3, 128'hC3B2A1);
    chk("R3 ready drops after accept", {31'd0, tx_ready}, 32'd0);
    wait_frame(1'b0, "R4 send begins");
    chk("R4 ack high at start", {31'd0, ack}, 32'd1);
    take("R4 byte 0");
    chk("R5 ack inverted", {31'd0, ack}, 32'd0);
    take("R5 byte 1");
    chk("R5 ack inverted again", {31'd0, ack}, 32'd1);
    take("R5 byte 2");
    chk("R6 lines idle after last", {29'd0, frame_n, ack, sh_dir_out}, 32'd6);
    chk("R6 ready again", {31'd0, tx_ready}, 32'd1);

    // one-byte send boundary
    offer(1, 128'h5A);
    wait_frame(1'b0, "R4 single byte start");
    take("R6 single byte");
    chk("R6 single byte ends send", {30'd0, frame_n, sh_dir_out}, 32'd2);

    // unsolicited receive
    cyc(2);
    strobe(8'hEE, 1'b0);
    chk("R8 receive starts, dummy dropped", {30'd0, frame_n, sh_dir_out}, 32'd0);
    rx_frame(8'h55, 3, 8'h10, 1'b1);
    chk("R10 lines idle after frame", {30'd0, frame_n, ack}, 32'd3);

    // spurious start, nothing pending
    cyc(2);
    strobe(8'h77, 1'b1);
    chk("R8 spurious start ignored", {30'd0, frame_n, busy}, 32'd2);

    // spurious start with a freshly accepted packet
    tx_valid = 1'b1; tx_len = 5'd2; tx_data = 128'h2211;
    txq.push_back(8'h11); txq.push_back(8'h22);
    @(negedge clk);
    tx_valid = 1'b0;
    strobe(8'h00, 1'b1);
    chk("R8 guard after spurious start", {30'd0, frame_n, busy}, 32'd3);
    wait_frame(1'b0, "R8 send restarts");
    take("R8 restart from byte 0");
    take("R8 second byte");

    // collision on byte 1, then replay
    offer(4, 128'h34333231);
    wait_frame(1'b0, "R7 send begins");
    chk("R7 first pass byte 0", {24'd0, sh_wr_byte}, 32'h31);
    strobe(8'h00, 1'b1);
    chk("R7 first pass byte 1", {24'd0, sh_wr_byte}, 32'h32);
    strobe(8'h00, 1'b0);
    chk("R7 collision idles lines", {28'd0, frame_n, ack, sh_dir_out, busy}, 32'hD);
    wait_frame(1'b0, "R7 receive after guard");
    chk("R7 input direction", {31'd0, sh_dir_out}, 32'd0);
    rx_frame(8'h02, 1, 8'h40, 1'b1);
    chk("R12 settle wait after receive", {30'd0, frame_n, busy}, 32'd3);
    wait_frame(1'b0, "R12 send replayed");
    for (int i = 0; i < 4; i++) take("R7 replay from byte 0");
    chk("R6 replay completes", {30'd0, frame_n, tx_ready}, 32'd3);

    // settle ends with request low: second receive, then send
    offer(2, 128'h6261);
    wait_frame(1'b0, "R7 send begins");
    strobe(8'h00, 1'b0);
    wait_frame(1'b0, "R7 receive after collision");
    rx_frame(8'h03, 0, 8'h00, 1'b1);
    cyc(5);
    req_n = 1'b0;
    wait_frame(1'b0, "R12 receive chosen after settle");
    chk("R12 receive direction", {30'd0, sh_dir_out, ack}, 32'd1);
    rx_frame(8'h04, 2, 8'h80, 1'b1);
    wait_frame(1'b0, "R12 send after second settle");
    take("R12 byte 0 again");
    take("R12 byte 1");

    // overflow at the buffer limit
    cyc(2);
    strobe(8'hEE, 1'b0);
    rx_frame(8'h99, 255, 8'h00, 1'b0);
    chk("R11 overflow ends frame", {30'd0, frame_n, ack}, 32'd3);
    req_n = 1'b1;

    cyc(5);
    chk("R9 R10 all expected items seen", rbq.size() + frq.size() + txq.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule